// File: doc/BRIEF.md
# Cache Tag Array Access Port

This block gives software direct load/store access to the tag, dirty and valid storage of a two-way, 512-set data cache. It does this through a memory-mapped window. The block decodes a 32-bit access address and the 32-bit write data. It then reads a line's tag and status, overwrites them, or runs an associative write.

An associative write searches both ways of one set for a tag and edits the status of the way that matches. A line that is dirty and is about to be invalidated or cleaned must first be evicted. The block asks for this eviction over a request/acknowledge handshake, and it holds off further accesses until the acknowledge arrives. A second window next to the tag window does not touch the tags. It only decodes which way, set and longword of the line data storage an access selects, and passes that selection on.

Top module: `tag_array_port`

## Requirements
- R1: After reset every tag, dirty flag and valid flag is 0. `ready` is 1, `wbReq`, `err`, `rdValid` and `dataStb` are 0, and any tag-window read returns 0.
- R2: An access is accepted on a clock edge where `reqValid` and `ready` are both 1. Address bits [31:24] = 0xF4 select the tag window and 0xF5 selects the data window. Any other value causes no state change and no output pulse.
- R3: An aligned tag-window read drives `rdValid` high for one cycle, on the cycle after acceptance. In that cycle `rdData` holds the stored tag in [31:10], the dirty flag in bit 1, the valid flag in bit 0, and 0 in bits [9:2]. Address bit 14 selects the way and bits [13:5] select the set.
- R4: A direct tag-window write has address bit 3 = 0. It stores write-data bits [31:10] as the tag, bit 1 as the dirty flag and bit 0 as the valid flag in the way selected by bit 14 and the set selected by bits [13:5]. If that line was both dirty and valid, the block first raises `wbReq` with the old tag, set and way. The new values are stored on the edge where `wbAck` is seen.
- R5: While `wbReq` is high, `ready` is 0 and `wbTag`, `wbIdx` and `wbWay` do not change. `wbReq` falls, and `ready` returns to 1, on the cycle after the edge where `wbAck` is 1.
- R6: An associative write has address bit 3 = 1. Address bit 14 is ignored. The write-data tag is compared with the tag of both ways of the addressed set. The first way, counting from way 0, that matches and has its valid flag at 1 gets its dirty and valid flags from write-data bits 1 and 0. Its tag is left unchanged.
- R7: An associative write that hits a dirty line and writes 0 to either the dirty or the valid flag first raises `wbReq` with that line's tag, set and way. The update is applied on the edge where `wbAck` is seen.
- R8: An associative write that finds no valid matching way, or that arrives with `xlatMiss` = 1, updates nothing, raises no `wbReq` and raises no `err`.
- R9: A tag-window or data-window access is in error when address bits [1:0] are not 0 or `reqSize` is not 2'b10 (longword). It pulses `err` on the cycle after acceptance and changes no state. It also produces no `rdValid`, no `dataStb` and no `wbReq`.
- R10: An aligned data-window access pulses `dataStb` on the cycle after acceptance. In that cycle `dataWay` comes from address bit 14, `dataIdx` from bits [13:5] and `dataWord` from bits [4:2].
- R11: When `ramMode` is 1, `dataWay` comes from address bit 13 instead of bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Access address |
| reqWdata | input | 32 | Write data |
| reqSize | input | 2 | Access size, 2'b10 = longword |
| xlatMiss | input | 1 | Translation of the associative tag failed |
| ramMode | input | 1 | Data window takes its way from bit 13 |
| ready | output | 1 | Block can accept an access |
| err | output | 1 | Misaligned or wrong-size access (pulse) |
| rdValid | output | 1 | Read data valid (pulse) |
| rdData | output | 32 | Tag, dirty flag and valid flag of the read line |
| wbReq | output | 1 | Eviction request |
| wbAck | input | 1 | Eviction done |
| wbTag | output | 22 | Tag of the line to evict |
| wbIdx | output | 9 | Set of the line to evict |
| wbWay | output | 1 | Way of the line to evict |
| dataStb | output | 1 | Data-window selection valid (pulse) |
| dataWay | output | 1 | Selected way |
| dataIdx | output | 9 | Selected set |
| dataWord | output | 3 | Selected longword |

## Verification
The assertions check the eviction handshake on every cycle:
- the request fields stay stable while the acknowledge is awaited;
- the request only starts from an accepted write and only ends after an acknowledge;
- an error never starts an eviction;
- a committed write lands in the valid storage.

Only the bench scenarios can show the rest: which way an associative search picks, that a miss or a translation failure leaves the line untouched, the old tag reported on eviction, and the data-window way selection in both modes. The bench checks these against a behavioural model by reading the lines back.

// File: rtl/tagport_pkg.sv
package tagport_pkg;
  localparam int TagW  = 22;
  localparam int IdxW  = 9;
  localparam int WordW = 3;

  typedef struct packed {
    logic            wrEn;
    logic            wrWay;
    logic [IdxW-1:0] wrIdx;
    logic [TagW-1:0] wrTag;
    logic            wrU;
    logic            wrV;
    logic            rdEn;
    logic            rdWay;
    logic [IdxW-1:0] rdIdx;
  } ctlStb_t;
endpackage

// File: rtl/tagport_dp.sv
module tagport_dp
  import tagport_pkg::*;
#(
  parameter int Sets = 1 << IdxW
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStb_t                    stb,
  input  logic [IdxW-1:0]            lkIdx,
  output logic [1:0][TagW-1:0]       lkTag,
  output logic [1:0]                 lkU,
  output logic [1:0]                 lkV,
  output logic                       rdValid,
  output logic [31:0]                rdData
);
  localparam int PadW = 32 - TagW - 2;

  logic [TagW-1:0] tagMem [2][Sets];
  logic [Sets-1:0] uMem [2];
  logic [Sets-1:0] vMem [2];

  for (genvar w = 0; w < 2; w++) begin : g_way
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < Sets; i++) tagMem[w][i] <= '0;
        uMem[w] <= '0;
        vMem[w] <= '0;
      end else if (stb.wrEn && (stb.wrWay == w[0])) begin
        tagMem[w][stb.wrIdx] <= stb.wrTag;
        uMem[w][stb.wrIdx]   <= stb.wrU;
        vMem[w][stb.wrIdx]   <= stb.wrV;
      end
    end
    assign lkTag[w] = tagMem[w][lkIdx];
    assign lkU[w]   = uMem[w][lkIdx];
    assign lkV[w]   = vMem[w][lkIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdEn;
      if (stb.rdEn)
        rdData <= {tagMem[stb.rdWay][stb.rdIdx], {PadW{1'b0}},
                   uMem[stb.rdWay][stb.rdIdx], vMem[stb.rdWay][stb.rdIdx]};
    end
  end

  // R4: a committed write shows up in the valid storage on the next cycle
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> (vMem[$past(stb.wrWay)][$past(stb.wrIdx)] == $past(stb.wrV)));
endmodule

// File: rtl/tagport_ctrl.sv
module tagport_ctrl
  import tagport_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [31:0]          reqAddr,
  input  logic [31:0]          reqWdata,
  input  logic [1:0]           reqSize,
  input  logic                 xlatMiss,
  input  logic                 ramMode,
  input  logic [1:0][TagW-1:0] lkTag,
  input  logic [1:0]           lkU,
  input  logic [1:0]           lkV,
  output logic [IdxW-1:0]      lkIdx,
  output ctlStb_t              stb,
  output logic                 ready,
  output logic                 err,
  output logic                 wbReq,
  input  logic                 wbAck,
  output logic [TagW-1:0]      wbTag,
  output logic [IdxW-1:0]      wbIdx,
  output logic                 wbWay,
  output logic                 dataStb,
  output logic                 dataWay,
  output logic [IdxW-1:0]      dataIdx,
  output logic [WordW-1:0]     dataWord
);
  localparam logic [7:0] TagWin  = 8'hF4;
  localparam logic [7:0] DataWin = 8'hF5;
  localparam logic [1:0] LongSz  = 2'b10;

  typedef enum logic {ST_IDLE, ST_WB} state_t;
  state_t state;

  logic            accept, inTag, inData, aligned, assoc, reqWay;
  logic            newU, newV, hit0, hit1, anyHit, hitWay;
  logic [IdxW-1:0] reqIdx;
  logic [TagW-1:0] newTag;
  logic            goWb, capWay;
  logic [TagW-1:0] capTag, capOld;
  logic            pWay, pU, pV;
  logic [IdxW-1:0] pIdx;
  logic [TagW-1:0] pTag;
  logic            unusedAddrBits;

  assign unusedAddrBits = ^{reqAddr[23:15], reqWdata[9:2]};

  assign ready   = (state == ST_IDLE);
  assign wbReq   = (state == ST_WB);
  assign accept  = reqValid && ready;
  assign inTag   = (reqAddr[31:24] == TagWin);
  assign inData  = (reqAddr[31:24] == DataWin);
  assign aligned = (reqAddr[1:0] == 2'b00) && (reqSize == LongSz);
  assign assoc   = reqAddr[3];
  assign reqWay  = reqAddr[14];
  assign reqIdx  = reqAddr[13:5];
  assign newTag  = reqWdata[31:10];
  assign newU    = reqWdata[1];
  assign newV    = reqWdata[0];
  assign lkIdx   = reqIdx;

  assign hit0   = lkV[0] && (lkTag[0] == newTag);
  assign hit1   = lkV[1] && (lkTag[1] == newTag);
  assign anyHit = hit0 || hit1;
  assign hitWay = !hit0;

  always_comb begin
    stb    = '0;
    goWb   = 1'b0;
    capWay = reqWay;
    capTag = newTag;
    capOld = lkTag[reqWay];
    if (state == ST_WB) begin
      if (wbAck) begin
        stb.wrEn  = 1'b1;
        stb.wrWay = pWay;
        stb.wrIdx = pIdx;
        stb.wrTag = pTag;
        stb.wrU   = pU;
        stb.wrV   = pV;
      end
    end else if (accept && inTag && aligned) begin
      if (!reqWrite) begin
        stb.rdEn  = 1'b1;
        stb.rdWay = reqWay;
        stb.rdIdx = reqIdx;
      end else if (!assoc) begin
        if (lkU[reqWay] && lkV[reqWay]) goWb = 1'b1;
        else stb.wrEn = 1'b1;
      end else if (!xlatMiss && anyHit) begin
        capWay = hitWay;
        capTag = lkTag[hitWay];
        capOld = lkTag[hitWay];
        if (lkU[hitWay] && (!newU || !newV)) goWb = 1'b1;
        else stb.wrEn = 1'b1;
      end
      stb.wrWay = capWay;
      stb.wrIdx = reqIdx;
      stb.wrTag = capTag;
      stb.wrU   = newU;
      stb.wrV   = newV;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pWay     <= 1'b0;
      pIdx     <= '0;
      pTag     <= '0;
      pU       <= 1'b0;
      pV       <= 1'b0;
      wbTag    <= '0;
      err      <= 1'b0;
      dataStb  <= 1'b0;
      dataWay  <= 1'b0;
      dataIdx  <= '0;
      dataWord <= '0;
    end else begin
      err     <= accept && (inTag || inData) && !aligned;
      dataStb <= accept && inData && aligned;
      if (accept && inData && aligned) begin
        dataWay  <= ramMode ? reqAddr[13] : reqAddr[14];
        dataIdx  <= reqIdx;
        dataWord <= reqAddr[4:2];
      end
      if (goWb) begin
        state <= ST_WB;
        pWay  <= capWay;
        pIdx  <= reqIdx;
        pTag  <= capTag;
        pU    <= newU;
        pV    <= newV;
        wbTag <= capOld;
      end else if (state == ST_WB && wbAck) begin
        state <= ST_IDLE;
      end
    end
  end

  assign wbIdx = pIdx;
  assign wbWay = pWay;

  // R5: eviction fields hold while the acknowledge is awaited
  p_wb_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> (wbReq && $stable(wbTag) && $stable(wbIdx) && $stable(wbWay)));
  // R4: an eviction request only starts from an accepted write
  p_wb_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wbReq) |-> $past(reqValid && reqWrite));
  // R5: an eviction request only ends after an acknowledge
  p_wb_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wbReq) |-> $past(wbAck));
  // R9: an erroring access never starts an eviction or a data selection
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!$rose(wbReq) && !dataStb));
endmodule

// File: rtl/tag_array_port.sv
module tag_array_port
  import tagport_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [31:0]          reqAddr,
  input  logic [31:0]          reqWdata,
  input  logic [1:0]           reqSize,
  input  logic                 xlatMiss,
  input  logic                 ramMode,
  output logic                 ready,
  output logic                 err,
  output logic                 rdValid,
  output logic [31:0]          rdData,
  output logic                 wbReq,
  input  logic                 wbAck,
  output logic [TagW-1:0]      wbTag,
  output logic [IdxW-1:0]      wbIdx,
  output logic                 wbWay,
  output logic                 dataStb,
  output logic                 dataWay,
  output logic [IdxW-1:0]      dataIdx,
  output logic [WordW-1:0]     dataWord
);
  ctlStb_t             stb;
  logic [IdxW-1:0]     lkIdx;
  logic [1:0][TagW-1:0] lkTag;
  logic [1:0]          lkU, lkV;

  tagport_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqSize(reqSize),
    .xlatMiss(xlatMiss), .ramMode(ramMode), .lkTag(lkTag), .lkU(lkU),
    .lkV(lkV), .lkIdx(lkIdx), .stb(stb), .ready(ready), .err(err),
    .wbReq(wbReq), .wbAck(wbAck), .wbTag(wbTag), .wbIdx(wbIdx),
    .wbWay(wbWay), .dataStb(dataStb), .dataWay(dataWay),
    .dataIdx(dataIdx), .dataWord(dataWord)
  );

  tagport_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lkIdx(lkIdx), .lkTag(lkTag),
    .lkU(lkU), .lkV(lkV), .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: tb/test_tag_array_port.sv
module test_tag_array_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, xlatMiss = 1'b0, ramMode = 1'b0, wbAck = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [1:0]  reqSize = 2'b10;
  logic        ready, err, rdValid, wbReq, wbWay, dataStb, dataWay;
  logic [31:0] rdData;
  logic [21:0] wbTag;
  logic [8:0]  wbIdx, dataIdx;
  logic [2:0]  dataWord;

  tag_array_port i_tag_array_port (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqSize(reqSize),
    .xlatMiss(xlatMiss), .ramMode(ramMode), .ready(ready), .err(err),
    .rdValid(rdValid), .rdData(rdData), .wbReq(wbReq), .wbAck(wbAck),
    .wbTag(wbTag), .wbIdx(wbIdx), .wbWay(wbWay), .dataStb(dataStb),
    .dataWay(dataWay), .dataIdx(dataIdx), .dataWord(dataWord)
  );

  always #5 clk = ~clk;

  // behavioural model
  logic [21:0] mTag [2][512];
  bit          mU [2][512];
  bit          mV [2][512];
  bit          pWay, pU, pV;
  int          pIdx;
  logic [21:0] pTag;

  bit          expReady = 1, expErr = 0, expRd = 0, expWb = 0, expData = 0;
  logic [31:0] expRdData = '0;
  logic [21:0] expWbTag = '0;
  logic [8:0]  expWbIdx = '0, expDataIdx = '0;
  bit          expWbWay = 0, expDataWay = 0;
  logic [2:0]  expDataWord = '0;
  string       curReq = "R1";
  int          nChecks = 0, nErr = 0;

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rstN) begin
      check(ready === expReady, "ready (R5)", 32'(ready), 32'(expReady));
      check(err === expErr, "err (R9)", 32'(err), 32'(expErr));
      check(rdValid === expRd, "rdValid (R3)", 32'(rdValid), 32'(expRd));
      if (expRd) check(rdData === expRdData, "rdData (R3)", rdData, expRdData);
      check(wbReq === expWb, "wbReq (R5)", 32'(wbReq), 32'(expWb));
      if (expWb) begin
        check(wbTag === expWbTag, "wbTag", 32'(wbTag), 32'(expWbTag));
        check(wbIdx === expWbIdx, "wbIdx", 32'(wbIdx), 32'(expWbIdx));
        check(wbWay === expWbWay, "wbWay", 32'(wbWay), 32'(expWbWay));
      end
      check(dataStb === expData, "dataStb (R10)", 32'(dataStb), 32'(expData));
      if (expData) begin
        check(dataWay === expDataWay, "dataWay (R11)", 32'(dataWay), 32'(expDataWay));
        check(dataIdx === expDataIdx, "dataIdx (R10)", 32'(dataIdx), 32'(expDataIdx));
        check(dataWord === expDataWord, "dataWord (R10)", 32'(dataWord), 32'(expDataWord));
      end
    end
  end

  function automatic logic [31:0] tagAddr(input bit way, input int idx, input bit asc);
    return {8'hF4, 9'd0, way, 9'(idx), 1'b0, asc, 3'b000};
  endfunction

  function automatic logic [31:0] tagData(input logic [21:0] t, input bit u, input bit v);
    return {t, 8'd0, u, v};
  endfunction

  task automatic issue(input bit wr, input logic [31:0] addr, input logic [31:0] data, input logic [1:0] size);
    bit aligned, way, asc, u, v;
    int idx, hw;
    logic [21:0] t;
    aligned = (addr[1:0] == 2'b00) && (size == 2'b10);
    way = addr[14]; idx = int'(addr[13:5]); asc = addr[3];
    t = data[31:10]; u = data[1]; v = data[0];
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = addr; reqWdata = data; reqSize = size;
    if ((addr[31:24] == 8'hF4 || addr[31:24] == 8'hF5) && !aligned) begin
      expErr = 1;
    end else if (addr[31:24] == 8'hF5) begin
      expData = 1;
      expDataWay = ramMode ? addr[13] : addr[14];
      expDataIdx = addr[13:5];
      expDataWord = addr[4:2];
    end else if (addr[31:24] == 8'hF4) begin
      if (!wr) begin
        expRd = 1;
        expRdData = tagData(mTag[way][idx], mU[way][idx], mV[way][idx]);
      end else if (!asc) begin
        if (mU[way][idx] && mV[way][idx]) begin
          expWb = 1; expReady = 0;
          expWbTag = mTag[way][idx]; expWbIdx = 9'(idx); expWbWay = way;
          pWay = way; pIdx = idx; pTag = t; pU = u; pV = v;
        end else begin
          mTag[way][idx] = t; mU[way][idx] = u; mV[way][idx] = v;
        end
      end else if (!xlatMiss) begin
        hw = -1;
        for (int w = 0; w < 2; w++)
          if (hw < 0 && mV[w][idx] && mTag[w][idx] == t) hw = w;
        if (hw >= 0) begin
          if (mU[hw][idx] && (!u || !v)) begin
            expWb = 1; expReady = 0;
            expWbTag = mTag[hw][idx]; expWbIdx = 9'(idx); expWbWay = hw[0];
            pWay = hw[0]; pIdx = idx; pTag = mTag[hw][idx]; pU = u; pV = v;
          end else begin
            mU[hw][idx] = u; mV[hw][idx] = v;
          end
        end
      end
    end
    @(negedge clk);
    reqValid = 0; expErr = 0; expRd = 0; expData = 0;
  endtask

  task automatic ackWb(input int waitCycles);
    repeat (waitCycles) @(negedge clk);
    wbAck = 1;
    mTag[pWay][pIdx] = pTag; mU[pWay][pIdx] = pU; mV[pWay][pIdx] = pV;
    expWb = 0; expReady = 1;
    @(negedge clk);
    wbAck = 0;
  endtask

  task automatic rd(input bit way, input int idx);
    issue(0, tagAddr(way, idx, 0), 32'h0, 2'b10);
  endtask

  initial begin
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 512; i++) begin
        mTag[w][i] = '0; mU[w][i] = 0; mV[w][i] = 0;
      end
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    curReq = "R1";
    rd(0, 0); rd(1, 511);
    // R4: direct writes to clean lines, then read back (R3)
    curReq = "R4";
    issue(1, tagAddr(0, 5, 0), tagData(22'h0AAAAA, 0, 1), 2'b10);
    issue(1, tagAddr(1, 5, 0), tagData(22'h155555, 1, 1), 2'b10);
    curReq = "R3";
    rd(0, 5); rd(1, 5);
    // R4/R5: overwrite a dirty valid line -> eviction first
    curReq = "R5";
    issue(1, tagAddr(1, 5, 0), tagData(22'h012345, 0, 1), 2'b10);
    ackWb(3);
    curReq = "R4";
    rd(1, 5);
    // R6: associative write with the way bit pointing elsewhere
    curReq = "R6";
    issue(1, tagAddr(1, 5, 1), tagData(22'h0AAAAA, 0, 0), 2'b10);
    rd(0, 5); rd(1, 5);
    issue(1, tagAddr(0, 5, 1), tagData(22'h012345, 1, 1), 2'b10);
    rd(1, 5);
    // R7: associative clean of a dirty line -> eviction
    curReq = "R7";
    issue(1, tagAddr(0, 7, 0), tagData(22'h3C3C3C, 1, 1), 2'b10);
    issue(1, tagAddr(1, 7, 1), tagData(22'h3C3C3C, 0, 1), 2'b10);
    ackWb(1);
    rd(0, 7);
    // R8: miss and translation failure change nothing
    curReq = "R8";
    issue(1, tagAddr(0, 7, 1), tagData(22'h111111, 0, 0), 2'b10);
    rd(0, 7);
    xlatMiss = 1;
    issue(1, tagAddr(0, 7, 1), tagData(22'h3C3C3C, 0, 0), 2'b10);
    xlatMiss = 0;
    rd(0, 7);
    // R9: misaligned address and wrong size
    curReq = "R9";
    issue(1, tagAddr(0, 7, 0) | 32'h2, tagData(22'h0, 0, 0), 2'b10);
    issue(1, tagAddr(0, 7, 0), tagData(22'h0, 0, 0), 2'b01);
    issue(0, 32'hF500_0001, 32'h0, 2'b10);
    rd(0, 7);
    // R2: access outside both windows
    curReq = "R2";
    issue(1, 32'hF600_00E0, tagData(22'h0, 0, 0), 2'b10);
    issue(1, {8'hF0, tagAddr(0, 7, 0)}[31:0] & 32'hF0FF_FFFF, 32'h0, 2'b10);
    rd(0, 7);
    // R10 / R11: data window decode
    curReq = "R10";
    issue(0, 32'hF500_4FF4, 32'h0, 2'b10);
    issue(1, 32'hF500_2028, 32'h0, 2'b10);
    curReq = "R11";
    ramMode = 1;
    issue(0, 32'hF500_2028, 32'h0, 2'b10);
    issue(0, 32'hF500_4FF4, 32'h0, 2'b10);
    ramMode = 0;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    #2000000;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule